// File: doc/BRIEF.md
# CAN Global-Mask Acceptance Filter

This block decides which of fourteen receive message centers of a CAN controller will take an incoming frame. Every received identifier is compared at once with each center's stored arbitration value. A center that has masking switched on uses a global mask shared by all centers: the standard mask if the center is set for 11-bit identifiers, the extended mask if it is set for 29-bit identifiers. A center that has masking switched off compares exactly. The result is a per-center hit vector and the number of the lowest hitting center.

Software writes the two global masks through a small byte-wide register window. Writes take effect only while the controller's software-initialization control is set, so that the acceptance rules cannot change while frames are arriving. Each center drives four inputs into the block: a valid bit, an extended/standard flag, a mask-enable flag and a 29-bit arbitration slot. A standard center keeps its 11-bit identifier in slot bits 28..18.

Top module: `cgf_accept_filter`

## Requirements
- R1: For a center with masking enabled, an identifier bit whose global mask bit is 1 must equal the center's arbitration bit, and a bit whose mask bit is 0 is a don't-care.
- R2: For a center with masking disabled, the identifier must equal the arbitration value exactly on every compared bit, whatever the masks hold. Standard centers compare slot bits 28..18 and extended centers compare bits 28..0.
- R3: Standard centers use only the standard mask and extended centers use only the extended mask. The content of one mask has no effect on centers of the other format.
- R4: A standard frame's identifier is taken from id_value[10:0], and id_value[28:11] is ignored. It is compared at positions 28..18. Standard centers accept only standard frames (id_ext=0), and extended centers accept only extended frames (id_ext=1).
- R5: A center whose valid bit is 0 never matches.
- R6: Mask registers change only when reg_wr is high at a clock edge while init_mode is 1. A write at any other time leaves every mask unchanged.
- R7: Register map. Offset 6h holds standard mask bits 28..21 in data bits 7..0. Offset 7h holds standard mask bits 20..18 in data bits 7..5. Offsets 8h, 9h and Ah hold extended mask bits 28..21, 20..13 and 12..5. Offset Bh holds extended mask bits 4..0 in data bits 7..3. Unused data bits at 7h and Bh read 0 and ignore writes. Unmapped offsets read 0.
- R8: After reset every mask bit is 1, so offsets 6h..Bh read FF, E0, FF, FF, FF, F8. After reset match_vec, match_idx and match_strobe are 0.
- R9: The comparison result is registered at the clock edge where id_valid is 1. match_strobe is high for exactly the following cycle. match_vec and match_idx hold their values until the next id_valid.
- R10: match_idx is k when center k (vector bit k-1) is the lowest-numbered hitting center, and 0 when no center hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_mode | input | 1 | Software-initialization control; enables mask writes |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset for both read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| id_valid | input | 1 | A received identifier is present this cycle |
| id_ext | input | 1 | 1 = extended frame, 0 = standard frame |
| id_value | input | 29 | Received identifier (standard uses bits 10..0) |
| ctr_valid | input | 14 | Per-center valid bit |
| ctr_ext | input | 14 | Per-center extended-format flag |
| ctr_mask_en | input | 14 | Per-center global-mask enable |
| ctr_arb | input | 406 | Arbitration slots; center i+1 at bits 29*i+28..29*i |
| match_vec | output | 14 | Registered hit vector, bit i = center i+1 |
| match_idx | output | 4 | Lowest hitting center number, 0 = none |
| match_strobe | output | 1 | Result updated in the previous clock |

## Verification
A mask bit stored wrong shows up on reg_rdata as soon as its offset is addressed, in the same cycle. It shows on match_vec one clock after the first identifier that differs from an arbitration value only in that bit. A write that leaks outside initialization mode changes a readback at once and changes acceptance on the next identifier. A fault in the priority encoder or the result register shows as a match_idx that disagrees with match_vec, or as a strobe or result update in the wrong cycle. Each of these appears within one clock of the stimulus that exposes it.

// File: rtl/cgf_pkg.sv
package cgf_pkg;
  localparam int unsigned ID_W  = 29;
  localparam int unsigned STD_W = 11;
  localparam int unsigned STD_LSB = ID_W - STD_W;

  // A frame passes one compare when every enforced bit agrees.
  function automatic logic bits_agree(input logic [ID_W-1:0] frame_id,
                                      input logic [ID_W-1:0] arb,
                                      input logic [ID_W-1:0] enforce);
    return ((frame_id ^ arb) & enforce) == '0;
  endfunction

  // Place an 11-bit identifier at the top of the 29-bit field.
  function automatic logic [ID_W-1:0] place_std(input logic [STD_W-1:0] sid);
    return {sid, {STD_LSB{1'b0}}};
  endfunction
endpackage

// File: rtl/cgf_mask_regs.sv
module cgf_mask_regs
  import cgf_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_mode,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic [STD_W-1:0]  std_mask,
  output logic [ID_W-1:0]   ext_mask
);
  localparam logic [ADDR_W-1:0] OFS_STD_HI = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] OFS_STD_LO = ADDR_W'(7);
  localparam logic [ADDR_W-1:0] OFS_EXT_B3 = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] OFS_EXT_B2 = ADDR_W'(9);
  localparam logic [ADDR_W-1:0] OFS_EXT_B1 = ADDR_W'(10);
  localparam logic [ADDR_W-1:0] OFS_EXT_B0 = ADDR_W'(11);

  logic [STD_W-1:0] std_q;
  logic [ID_W-1:0]  ext_q;
  logic             wr_ok;

  assign wr_ok = reg_wr & init_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      std_q <= '1;
      ext_q <= '1;
    end else if (wr_ok) begin
      case (reg_addr)
        OFS_STD_HI: std_q[10:3]  <= reg_wdata;
        OFS_STD_LO: std_q[2:0]   <= reg_wdata[7:5];
        OFS_EXT_B3: ext_q[28:21] <= reg_wdata;
        OFS_EXT_B2: ext_q[20:13] <= reg_wdata;
        OFS_EXT_B1: ext_q[12:5]  <= reg_wdata;
        OFS_EXT_B0: ext_q[4:0]   <= reg_wdata[7:3];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      OFS_STD_HI: reg_rdata = std_q[10:3];
      OFS_STD_LO: reg_rdata = {std_q[2:0], 5'b0};
      OFS_EXT_B3: reg_rdata = ext_q[28:21];
      OFS_EXT_B2: reg_rdata = ext_q[20:13];
      OFS_EXT_B1: reg_rdata = ext_q[12:5];
      OFS_EXT_B0: reg_rdata = {ext_q[4:0], 3'b0};
      default:    reg_rdata = 8'h00;
    endcase
  end

  assign std_mask = std_q;
  assign ext_mask = ext_q;
endmodule

// File: rtl/cgf_center_cmp.sv
module cgf_center_cmp
  import cgf_pkg::*;
(
  input  logic             ctr_valid,
  input  logic             ctr_ext,
  input  logic             ctr_mask_en,
  input  logic [ID_W-1:0]  ctr_arb,
  input  logic             id_ext,
  input  logic [ID_W-1:0]  id_placed,
  input  logic [STD_W-1:0] std_mask,
  input  logic [ID_W-1:0]  ext_mask,
  output logic             hit
);
  logic [ID_W-1:0] enforce;
  logic            fmt_ok;

  always_comb begin
    if (ctr_ext)
      enforce = ctr_mask_en ? ext_mask : '1;
    else
      enforce = ctr_mask_en ? place_std(std_mask) : place_std('1);
  end

  assign fmt_ok = (ctr_ext == id_ext);
  assign hit    = ctr_valid & fmt_ok & bits_agree(id_placed, ctr_arb, enforce);
endmodule

// File: rtl/cgf_prio_enc.sv
module cgf_prio_enc #(
  parameter int unsigned N     = 14,
  parameter int unsigned IDX_W = $clog2(N + 1)
) (
  input  logic [N-1:0]     req,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i + 1);
    end
  end
endmodule

// File: rtl/cgf_accept_filter.sv
module cgf_accept_filter
  import cgf_pkg::*;
#(
  parameter int unsigned NUM_CTR = 14,
  parameter int unsigned ADDR_W  = 4,
  localparam int unsigned IDX_W  = $clog2(NUM_CTR + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    init_mode,
  input  logic                    reg_wr,
  input  logic [ADDR_W-1:0]       reg_addr,
  input  logic [7:0]              reg_wdata,
  output logic [7:0]              reg_rdata,
  input  logic                    id_valid,
  input  logic                    id_ext,
  input  logic [ID_W-1:0]         id_value,
  input  logic [NUM_CTR-1:0]      ctr_valid,
  input  logic [NUM_CTR-1:0]      ctr_ext,
  input  logic [NUM_CTR-1:0]      ctr_mask_en,
  input  logic [NUM_CTR*ID_W-1:0] ctr_arb,
  output logic [NUM_CTR-1:0]      match_vec,
  output logic [IDX_W-1:0]        match_idx,
  output logic                    match_strobe
);
  logic [STD_W-1:0]   std_mask;
  logic [ID_W-1:0]    ext_mask;
  logic [ID_W-1:0]    id_placed;
  logic [NUM_CTR-1:0] hit_now;
  logic [IDX_W-1:0]   idx_now;

  cgf_mask_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_mode (init_mode),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .std_mask  (std_mask),
    .ext_mask  (ext_mask)
  );

  assign id_placed = id_ext ? id_value : place_std(id_value[STD_W-1:0]);

  for (genvar c = 0; c < NUM_CTR; c++) begin : g_ctr
    cgf_center_cmp u_cmp (
      .ctr_valid   (ctr_valid[c]),
      .ctr_ext     (ctr_ext[c]),
      .ctr_mask_en (ctr_mask_en[c]),
      .ctr_arb     (ctr_arb[c*ID_W +: ID_W]),
      .id_ext      (id_ext),
      .id_placed   (id_placed),
      .std_mask    (std_mask),
      .ext_mask    (ext_mask),
      .hit         (hit_now[c])
    );
  end

  cgf_prio_enc #(.N(NUM_CTR), .IDX_W(IDX_W)) u_enc (
    .req (hit_now),
    .idx (idx_now)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_vec    <= '0;
      match_idx    <= '0;
      match_strobe <= 1'b0;
    end else begin
      match_strobe <= id_valid;
      if (id_valid) begin
        match_vec <= hit_now;
        match_idx <= idx_now;
      end
    end
  end
endmodule

// File: rtl/cgf_accept_filter_chk.sv
module cgf_accept_filter_chk #(
  parameter int unsigned NUM_CTR = 14,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned IDX_W   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               init_mode,
  input logic               reg_wr,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [7:0]         reg_rdata,
  input logic               id_valid,
  input logic [10:0]        std_mask,
  input logic [28:0]        ext_mask,
  input logic [NUM_CTR-1:0] match_vec,
  input logic [IDX_W-1:0]   match_idx,
  input logic               match_strobe
);
  a_r6_no_write_outside_init: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !init_mode) |=> ($stable(std_mask) && $stable(ext_mask)));

  a_r7_std_lo_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(7)) |-> (reg_rdata[4:0] == 5'b0));

  a_r7_ext_lo_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(11)) |-> (reg_rdata[2:0] == 3'b0));

  a_r9_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid |=> match_strobe);

  a_r9_quiet_without_id: assert property (@(posedge clk) disable iff (!rst_n)
    !id_valid |=> (!match_strobe && $stable(match_vec) && $stable(match_idx)));

  a_r10_zero_iff_none: assert property (@(posedge clk) disable iff (!rst_n)
    (match_idx == '0) == (match_vec == '0));

  a_r10_idx_is_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    (match_idx != '0) |->
      (match_vec[match_idx - 1'b1] &&
       ((match_vec & ((NUM_CTR'(1) << (match_idx - 1'b1)) - NUM_CTR'(1))) == '0)));
endmodule

bind cgf_accept_filter cgf_accept_filter_chk #(
  .NUM_CTR(NUM_CTR), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .init_mode    (init_mode),
  .reg_wr       (reg_wr),
  .reg_addr     (reg_addr),
  .reg_rdata    (reg_rdata),
  .id_valid     (id_valid),
  .std_mask     (std_mask),
  .ext_mask     (ext_mask),
  .match_vec    (match_vec),
  .match_idx    (match_idx),
  .match_strobe (match_strobe)
);

// File: tb/tb_cgf_accept_filter.sv
module tb_cgf_accept_filter;
  localparam int NC = 14;
  localparam int IW = 29;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           init_mode = 1'b0;
  logic           reg_wr = 1'b0;
  logic [3:0]     reg_addr = '0;
  logic [7:0]     reg_wdata = '0;
  logic [7:0]     reg_rdata;
  logic           id_valid = 1'b0;
  logic           id_ext = 1'b0;
  logic [IW-1:0]  id_value = '0;
  logic [NC-1:0]  ctr_valid = '0;
  logic [NC-1:0]  ctr_ext = '0;
  logic [NC-1:0]  ctr_mask_en = '0;
  logic [NC*IW-1:0] ctr_arb = '0;
  logic [NC-1:0]  match_vec;
  logic [3:0]     match_idx;
  logic           match_strobe;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  cgf_accept_filter dut (
    .clk(clk), .rst_n(rst_n), .init_mode(init_mode), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .id_valid(id_valid), .id_ext(id_ext), .id_value(id_value),
    .ctr_valid(ctr_valid), .ctr_ext(ctr_ext), .ctr_mask_en(ctr_mask_en),
    .ctr_arb(ctr_arb), .match_vec(match_vec), .match_idx(match_idx),
    .match_strobe(match_strobe)
  );

  // {id_ext, id_value[28:0], expected vec[13:0], expected idx[3:0]}
  localparam int NV = 9;
  localparam logic [47:0] VEC [NV] = '{
    {1'b0, 29'h0000_0123, 14'h0003, 4'd1},  // R1 R2: exact c1, masked c2
    {1'b0, 29'h0000_012F, 14'h0002, 4'd2},  // R1: low std bits don't-care
    {1'b0, 29'h0000_0133, 14'h0000, 4'd0},  // R1: enforced bit differs
    {1'b1, 29'h0ABC_DEF1, 14'h000C, 4'd3},  // R2 R3 R10: ext exact and masked
    {1'b1, 29'h0ABC_DE00, 14'h0008, 4'd4},  // R2 R3: exact ext rejects
    {1'b1, 29'h1FFF_FF12, 14'h0020, 4'd6},  // R3: ext mask low byte free
    {1'b1, 29'h048C_0000, 14'h0000, 4'd0},  // R4: ext frame vs std centers
    {1'b0, 29'h0000_07FF, 14'h0000, 4'd0},  // R1: no hit
    {1'b0, 29'h1FFF_F923, 14'h0003, 4'd1}   // R4: upper std bits ignored
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [3:0] a, input logic [7:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(req, {24'b0, reg_rdata}, {24'b0, exp});
  endtask

  task automatic send(input logic e, input logic [IW-1:0] v);
    @(negedge clk);
    id_ext = e; id_value = v; id_valid = 1'b1;
    @(negedge clk);
    id_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    // Center setup (bit i = center i+1)
    ctr_valid   = 14'b10_1111;
    ctr_ext     = 14'b10_1100;
    ctr_mask_en = 14'b10_1010;
    ctr_arb[0*IW +: IW] = 29'h123 << 18;
    ctr_arb[1*IW +: IW] = 29'h120 << 18;
    ctr_arb[2*IW +: IW] = 29'h0ABC_DEF1;
    ctr_arb[3*IW +: IW] = 29'h0ABC_DE00;
    ctr_arb[4*IW +: IW] = 29'h123 << 18;
    ctr_arb[5*IW +: IW] = 29'h1FFF_FFFF;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R8: reset state
    check("R8 vec", {18'b0, match_vec}, 32'h0);
    check("R8 idx", {28'b0, match_idx}, 32'h0);
    check("R8 strobe", {31'b0, match_strobe}, 32'h0);
    rd_check("R8 reg6", 4'h6, 8'hFF);
    rd_check("R8 reg7", 4'h7, 8'hE0);
    rd_check("R8 reg8", 4'h8, 8'hFF);
    rd_check("R8 reg9", 4'h9, 8'hFF);
    rd_check("R8 regA", 4'hA, 8'hFF);
    rd_check("R8 regB", 4'hB, 8'hF8);
    rd_check("R7 unmapped", 4'h3, 8'h00);

    // R6: write outside init ignored
    wr(4'h6, 8'h00);
    rd_check("R6 blocked", 4'h6, 8'hFF);

    // R7: reserved bits
    init_mode = 1'b1;
    wr(4'h7, 8'h1F);
    rd_check("R7 reg7 reserved", 4'h7, 8'h00);
    wr(4'hB, 8'hFF);
    rd_check("R7 regB reserved", 4'hB, 8'hF8);

    // Program std mask 0x7F0 and ext mask 0x1FFFFF00
    wr(4'h6, 8'hFE);
    wr(4'h7, 8'h00);
    wr(4'h8, 8'hFF);
    wr(4'h9, 8'hFF);
    wr(4'hA, 8'hF8);
    wr(4'hB, 8'h00);
    init_mode = 1'b0;
    rd_check("R7 reg6", 4'h6, 8'hFE);
    rd_check("R7 regA", 4'hA, 8'hF8);

    // R6: late write does not change content nor acceptance
    wr(4'h6, 8'hFF);
    rd_check("R6 blocked after init", 4'h6, 8'hFE);

    for (int i = 0; i < NV; i++) begin
      send(VEC[i][47], VEC[i][46:18]);
      check("R1 R2 R3 R4 R5 vec", {18'b0, match_vec}, {18'b0, VEC[i][17:4]});
      check("R10 idx", {28'b0, match_idx}, {28'b0, VEC[i][3:0]});
    end

    // R9: strobe one cycle, result holds
    send(1'b0, 29'h123);
    check("R9 strobe high", {31'b0, match_strobe}, 32'h1);
    @(negedge clk);
    id_value = 29'h7FF;
    @(negedge clk);
    check("R9 strobe low", {31'b0, match_strobe}, 32'h0);
    check("R9 vec held", {18'b0, match_vec}, 32'h3);

    // R5: enabling center 5 makes it hit
    ctr_valid[4] = 1'b1;
    send(1'b0, 29'h123);
    check("R5 valid center", {18'b0, match_vec}, 32'h13);

    // R3: std mask cleared leaves ext centers unchanged
    init_mode = 1'b1;
    wr(4'h6, 8'h00);
    wr(4'h7, 8'h00);
    init_mode = 1'b0;
    send(1'b1, 29'h0ABC_DE00);
    check("R3 ext ignores std mask", {18'b0, match_vec}, 32'h8);
    send(1'b0, 29'h555);
    check("R1 std all don't-care", {18'b0, match_vec}, 32'h2);
    check("R10 idx", {28'b0, match_idx}, 32'h2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule